// File: doc/BRIEF.md
# Binary Tree Route Sequencer

This block works out the path a message takes through a binary tree network and hands it out one hop at a time. Every leaf has an address of `ADDR_W` bits, read from the most significant bit down as the left/right choice made at each level below the root. A request carries a source leaf and a destination leaf. The block XORs the two addresses. The most significant set bit of that result, at position `i`, gives the nearest common ancestor. The message climbs `i+1` levels to reach it and then descends `i+1` levels, steered by destination bits `i` down to `0`.

The block takes a request on a valid/ready handshake. It then issues one directive per accepted output beat: climb, descend to the left child, descend to the right child, or deliver locally when source and destination are the same leaf. The final directive of every route is flagged. A new request is accepted only once the final directive of the current route has been taken downstream.

Top module: `tree_route_unit`

## Requirements
- R1: After reset, `hop_valid_o` is low and `req_ready_o` is high.
- R2: `req_ready_o` is high exactly when no route is being issued. A request is accepted only on a cycle where `req_valid_i` and `req_ready_o` are both high. After the final directive is accepted, `hop_valid_o` is low on the next cycle.
- R3: When the source equals the destination, the route is a single directive of code 2'b00 (deliver locally), and `hop_last_o` is high with it.
- R4: When the source and destination differ, let `i` be the position of the most significant 1 in source XOR destination. The route begins with exactly `i+1` directives of code 2'b01 (climb).
- R5: The climb directives are followed by exactly `i+1` descend directives. The j-th of these, counting from 0, uses destination bit `i-j`: 0 gives code 2'b10 (left child) and 1 gives code 2'b11 (right child).
- R6: `hop_last_o` is high only on the final directive of a route, which is the last descend directive or the single local directive.
- R7: While `hop_valid_o` is high and `hop_ready_i` is low, the directive and `hop_last_o` hold their values.
- R8: The first directive of a route is presented in the cycle after the request is accepted.
- R9: A route between two different leaves contains exactly 2(i+1) directives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Route request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| src_i | input | ADDR_W | Source leaf address |
| dst_i | input | ADDR_W | Destination leaf address |
| hop_valid_o | output | 1 | Directive present |
| hop_ready_i | input | 1 | Downstream takes the directive |
| hop_dir_o | output | 2 | 00 local, 01 climb, 10 left child, 11 right child |
| hop_last_o | output | 1 | Final directive of the route |

## Verification
A wrong level counter shows up at the ports as a climb run or a descend run of the wrong length. A wrong captured destination shows up as a wrong left/right choice. Either fault appears within the route in which it occurs, and at the latest on the route's final beat, where `hop_last_o` would come early or late. A phase fault that fails to return to idle leaves `req_ready_o` low on the cycle after the final beat, so the next request cannot start and the fault is seen at once.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;
  typedef enum logic [1:0] {
    HOP_LOCAL = 2'b00,
    HOP_UP    = 2'b01,
    HOP_LEFT  = 2'b10,
    HOP_RIGHT = 2'b11
  } hop_dir_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_UP,
    PH_DOWN,
    PH_LOCAL
  } phase_e;
endpackage

// File: rtl/tr_msb_find.sv
module tr_msb_find #(
  parameter int W     = 6,
  parameter int POS_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec_i,
  output logic             any_o,
  output logic [POS_W-1:0] pos_o
);
  always_comb begin
    pos_o = '0;
    for (int b = 0; b < W; b++) begin
      if (vec_i[b]) pos_o = POS_W'(b);
    end
  end

  assign any_o = |vec_i;

  // The reported bit is set and nothing above it is set.
  always_comb begin
    if (any_o) begin
      assert_msb_found_R4: assert (vec_i[pos_o] && ((vec_i >> pos_o) == W'(1)))
        else $error("msb position wrong");
    end
  end
endmodule

// File: rtl/tr_route_plan.sv
module tr_route_plan #(
  parameter int ADDR_W = 6,
  parameter int LVL_W  = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  output logic              same_o,
  output logic [LVL_W-1:0]  top_lvl_o
);
  logic [ADDR_W-1:0] rel;
  logic              differ;

  assign rel = src_i ^ dst_i;

  tr_msb_find #(.W(ADDR_W), .POS_W(LVL_W)) u_msb (
    .vec_i (rel),
    .any_o (differ),
    .pos_o (top_lvl_o)
  );

  assign same_o = ~differ;
endmodule

// File: rtl/tr_hop_seq.sv
module tr_hop_seq
  import tree_route_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LVL_W  = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              same_i,
  input  logic [LVL_W-1:0]  top_lvl_i,
  input  logic [ADDR_W-1:0] dst_i,
  output logic              idle_o,
  output logic              hop_valid_o,
  input  logic              hop_ready_i,
  output hop_dir_e          hop_dir_o,
  output logic              hop_last_o
);
  phase_e            phase_q;
  logic [LVL_W-1:0]  cnt_q;
  logic [LVL_W-1:0]  top_q;
  logic [ADDR_W-1:0] dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      top_q   <= '0;
      dst_q   <= '0;
    end else if (phase_q == PH_IDLE) begin
      if (start_i) begin
        phase_q <= same_i ? PH_LOCAL : PH_UP;
        cnt_q   <= top_lvl_i;
        top_q   <= top_lvl_i;
        dst_q   <= dst_i;
      end
    end else if (hop_ready_i) begin
      unique case (phase_q)
        PH_UP: begin
          if (cnt_q == '0) begin
            phase_q <= PH_DOWN;
            cnt_q   <= top_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_DOWN: begin
          if (cnt_q == '0) phase_q <= PH_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign idle_o      = (phase_q == PH_IDLE);
  assign hop_valid_o = ~idle_o;

  always_comb begin
    unique case (phase_q)
      PH_UP:   hop_dir_o = HOP_UP;
      PH_DOWN: hop_dir_o = dst_q[cnt_q] ? HOP_RIGHT : HOP_LEFT;
      default: hop_dir_o = HOP_LOCAL;
    endcase
  end

  assign hop_last_o = (phase_q == PH_LOCAL) || ((phase_q == PH_DOWN) && (cnt_q == '0));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hop_valid_o && !hop_ready_i |=> hop_valid_o && $stable(hop_dir_o) && $stable(hop_last_o))
    else $error("directive changed under backpressure");

  assert_local_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hop_valid_o && hop_dir_o == HOP_LOCAL |-> hop_last_o)
    else $error("local directive not flagged last");

  assert_climb_not_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hop_valid_o && hop_dir_o == HOP_UP |-> !hop_last_o)
    else $error("climb directive flagged last");

  assert_down_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hop_valid_o && hop_ready_i && hop_dir_o[1] && !hop_last_o |=> hop_valid_o && hop_dir_o[1])
    else $error("descend run interrupted");

  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hop_valid_o && hop_ready_i && hop_last_o |=> !hop_valid_o)
    else $error("route continued past last");
endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit
  import tree_route_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  output logic              hop_valid_o,
  input  logic              hop_ready_i,
  output logic [1:0]        hop_dir_o,
  output logic              hop_last_o
);
  localparam int LVL_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

  logic             same;
  logic [LVL_W-1:0] top_lvl;
  logic             idle;
  logic             start;
  hop_dir_e         dir;

  tr_route_plan #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_plan (
    .src_i     (src_i),
    .dst_i     (dst_i),
    .same_o    (same),
    .top_lvl_o (top_lvl)
  );

  assign start = req_valid_i & idle;

  tr_hop_seq #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .same_i      (same),
    .top_lvl_i   (top_lvl),
    .dst_i       (dst_i),
    .idle_o      (idle),
    .hop_valid_o (hop_valid_o),
    .hop_ready_i (hop_ready_i),
    .hop_dir_o   (dir),
    .hop_last_o  (hop_last_o)
  );

  assign req_ready_o = idle;
  assign hop_dir_o   = dir;

  assert_launch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> hop_valid_o && !req_ready_o)
    else $error("route did not start after accept");
endmodule

// File: tb/tree_route_unit_test.sv
module tree_route_unit_test;
  localparam int ADDR_W  = 6;
  localparam int CLK_PER = 10;
  localparam int NADDR   = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] src = '0;
  logic [ADDR_W-1:0] dst = '0;
  logic              hop_valid;
  logic              hop_ready = 1'b0;
  logic [1:0]        hop_dir;
  logic              hop_last;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tree_route_unit #(.ADDR_W(ADDR_W)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .src_i       (src),
    .dst_i       (dst),
    .hop_valid_o (hop_valid),
    .hop_ready_i (hop_ready),
    .hop_dir_o   (hop_dir),
    .hop_last_o  (hop_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (time %0t)", req, act, exp, $time);
    end
  endtask

  function automatic int top_bit(input int r);
    int p = -1;
    for (int b = 0; b < ADDR_W; b++) if (r[b]) p = b;
    return p;
  endfunction

  // Expected directive k of route a->b
  function automatic int exp_dir(input int a, input int b, input int k);
    int i = top_bit(a ^ b);
    if (i < 0) return 0;
    if (k <= i) return 1;
    return b[i - (k - (i + 1))] ? 3 : 2;
  endfunction

  task automatic run_route(input int a, input int b, input int mode);
    int i = top_bit(a ^ b);
    int n = (i < 0) ? 1 : 2 * (i + 1);
    int k = 0;
    check(req_ready === 1'b1, "R2 idle before request", int'(req_ready), 1);
    req_valid = 1'b1;
    src = ADDR_W'(a);
    dst = ADDR_W'(b);
    @(posedge clk);
    @(negedge clk);
    check(hop_valid === 1'b1, "R8 first directive next cycle", int'(hop_valid), 1);
    // keep a junk request pending while busy: must not be taken (R2)
    src = ~ADDR_W'(a);
    dst = ADDR_W'(b) ^ ADDR_W'(1);
    while (k < n) begin
      hop_ready = (mode == 0) ? 1'b1 : (((cyc * 7 + a) % 5) > 1);
      check(hop_valid === 1'b1, "R9 route length", k, n);
      check(req_ready === 1'b0, "R2 busy blocks requests", int'(req_ready), 0);
      if (i < 0) check(hop_dir === 2'b00, "R3 local directive", int'(hop_dir), 0);
      else if (k <= i) check(hop_dir === 2'b01, "R4 climb directive", int'(hop_dir), 1);
      else check(int'(hop_dir) == exp_dir(a, b, k), "R5 descend directive", int'(hop_dir), exp_dir(a, b, k));
      check(hop_last === (k == n - 1), "R6 last flag", int'(hop_last), int'(k == n - 1));
      @(posedge clk);
      if (hop_ready) k++;
      else begin
        @(negedge clk);
        check(hop_valid === 1'b1 && int'(hop_dir) == exp_dir(a, b, k), "R7 hold under backpressure",
              int'(hop_dir), exp_dir(a, b, k));
        continue;
      end
      @(negedge clk);
    end
    hop_ready = 1'b0;
    check(hop_valid === 1'b0, "R2 valid drops after last", int'(hop_valid), 0);
    check(req_ready === 1'b1, "R2 ready after last", int'(req_ready), 1);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(hop_valid === 1'b0, "R1 reset valid", int'(hop_valid), 0);
    check(req_ready === 1'b1, "R1 reset ready", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(hop_valid === 1'b0, "R1 valid after release", int'(hop_valid), 0);
    for (int a = 0; a < NADDR; a++) begin
      for (int b = 0; b < NADDR; b++) begin
        run_route(a, b, (a + b) % 2);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule